// File: doc/BRIEF.md
# Triggered ADC Capture Sequencer

This block controls the acquisition window of one ADC channel. It derives a sample strobe from the system clock. The strobe period is set by a programmable divider. The block then moves through a fixed set of phases and reports each phase as a 4-bit status code. It also drives a write-enable toward a local FIFO, one write per sample strobe in every phase that captures data.

A capture is armed by command. If the programmed pre-trigger count is non-zero, writing starts at once. The block first fills the pre-trigger window. It then keeps writing as a circular window while it waits for the start trigger. If the pre-trigger count is zero, nothing is written until the start trigger arrives. A stop trigger ends the sampling phase. A post-stop fill of exactly the programmed count follows. After that the block finishes in the done phase, or, when re-arming is enabled, it waits until the FIFO is empty and then arms itself again. A converter that needs initialization starts out uninitialized and must run a fixed-length initialization sequence first.

Top module: `adc_capture_seq`

## Requirements
- R1: After reset, `status` is 8 when `need_init` is 1 and 0 when `need_init` is 0, and `fifo_wr` is 0.
- R2: While uninitialized with `need_init` high, `arm_cmd` is ignored (status stays 8). An `init_cmd` puts the block into status 9 for exactly 16 clocks, after which status is 0.
- R3: With a divider value D in 4..100, `sample_stb` is a one-clock pulse repeating every 2·D clocks. With D = 0 no strobe is produced.
- R4: Divider values 1..3 behave as 4, and values above 100 behave as 100.
- R5: An arm with a non-zero pre-trigger count N gives status 1 and writes on exactly N strobes. Status then becomes 2, and one write per strobe continues while waiting.
- R6: An arm with a pre-trigger count of 0 gives status 2 directly, and no writes occur before the start trigger.
- R7: Status 2 holds until `start_trig`. The block then shows status 3 and writes on every strobe until `stop_trig`.
- R8: After `stop_trig`, status 4 writes exactly the post-stop count M of samples. The block then goes to status 7 when `rearm_en` is 0; M = 0 skips status 4.
- R9: With `rearm_en` high, the end of the post-stop fill gives status 5. No writes occur in status 5, and the block stays there while `fifo_empty` is 0. One clock after `fifo_empty` is 1, it re-arms (status 1 or 2).
- R10: `reset_cmd` in any state other than 8 or 9 gives status 0 on the next clock, and no writes follow.
- R11: `fifo_wr` is high only in a cycle where `sample_stb` is high.
- R12: `status` only ever takes the values 0, 1, 2, 3, 4, 5, 7, 8 or 9.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| need_init | input | 1 | Converter requires an initialization sequence |
| init_cmd | input | 1 | Start initialization (pulse) |
| arm_cmd | input | 1 | Arm a capture (pulse) |
| reset_cmd | input | 1 | Abort to the stopped state (pulse) |
| rearm_en | input | 1 | Re-arm automatically after the post-stop fill |
| start_trig | input | 1 | Qualified start trigger pulse |
| stop_trig | input | 1 | Qualified stop trigger pulse |
| fifo_empty | input | 1 | Local FIFO is empty |
| clk_div | input | 8 | Sample strobe divider; 0 disables the strobe |
| pre_count | input | 16 | Pre-trigger sample count |
| post_count | input | 16 | Post-stop sample count |
| status | output | 4 | Current phase code |
| sample_stb | output | 1 | Sample strobe |
| fifo_wr | output | 1 | FIFO write enable |

## Verification
The strobe is measured as the gap between consecutive pulses for in-range, clamped-low, clamped-high and zero divider values. This shows the period rule apart from the clamp. Captures run with a non-zero pre-trigger count, a zero pre-trigger count, a zero post-stop count, and re-arming with a FIFO that stays full and then drains. Writes are counted per status code, so that immediate-start capture can be told apart from trigger-gated capture and an exact-length fill from an off-by-one. Aborts during pre-fill and during sampling show that the reset command overrides every capturing phase.

// File: rtl/adc_capture_seq.sv
module adc_capture_seq #(
  parameter int CNT_W       = 16,
  parameter int DIV_W       = 8,
  parameter int DIV_MIN     = 4,
  parameter int DIV_MAX     = 100,
  parameter int INIT_CYCLES = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             need_init,
  input  logic             init_cmd,
  input  logic             arm_cmd,
  input  logic             reset_cmd,
  input  logic             rearm_en,
  input  logic             start_trig,
  input  logic             stop_trig,
  input  logic             fifo_empty,
  input  logic [DIV_W-1:0] clk_div,
  input  logic [CNT_W-1:0] pre_count,
  input  logic [CNT_W-1:0] post_count,
  output logic [3:0]       status,
  output logic             sample_stb,
  output logic             fifo_wr
);
  localparam int INIT_W = $clog2(INIT_CYCLES + 1);
  localparam logic [DIV_W-1:0]  DMIN = DIV_W'(DIV_MIN);
  localparam logic [DIV_W-1:0]  DMAX = DIV_W'(DIV_MAX);
  localparam logic [INIT_W-1:0] ILAST = INIT_W'(INIT_CYCLES - 1);

  typedef enum logic [3:0] {
    S_STOP = 4'h0, S_PRE = 4'h1, S_WAIT = 4'h2, S_SAMP = 4'h3, S_POST = 4'h4,
    S_REARM = 4'h5, S_DONE = 4'h7, S_UNINIT = 4'h8, S_INIT = 4'h9
  } state_t;

  state_t            state;
  logic [CNT_W-1:0]  cnt;
  logic [INIT_W-1:0] init_cnt;
  logic              pre_mode;

  logic [DIV_W-1:0] div_eff;
  logic [DIV_W:0]   div_cnt;
  logic [DIV_W:0]   period;

  always_comb begin
    if (clk_div == '0)       div_eff = '0;
    else if (clk_div < DMIN) div_eff = DMIN;
    else if (clk_div > DMAX) div_eff = DMAX;
    else                     div_eff = clk_div;
  end

  assign period     = {div_eff, 1'b0};
  assign sample_stb = (div_eff != '0) && (div_cnt >= period - 1'b1);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                            div_cnt <= '0;
    else if (div_eff == '0 || sample_stb)  div_cnt <= '0;
    else                                   div_cnt <= div_cnt + 1'b1;

  logic             pre_nz, post_nz;
  logic [CNT_W-1:0] cnt_inc;
  state_t           arm_state, end_state;

  assign pre_nz    = pre_count != '0;
  assign post_nz   = post_count != '0;
  assign cnt_inc   = cnt + 1'b1;
  assign arm_state = pre_nz ? S_PRE : S_WAIT;
  assign end_state = rearm_en ? S_REARM : S_DONE;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= S_UNINIT;
      cnt      <= '0;
      init_cnt <= '0;
      pre_mode <= 1'b0;
    end else if (reset_cmd && state != S_UNINIT && state != S_INIT) begin
      state <= S_STOP;
      cnt   <= '0;
    end else begin
      case (state)
        S_UNINIT:
          if (init_cmd) begin
            state    <= S_INIT;
            init_cnt <= '0;
          end else if (arm_cmd && !need_init) begin
            state    <= arm_state;
            pre_mode <= pre_nz;
            cnt      <= '0;
          end
        S_INIT:
          if (init_cnt == ILAST) state <= S_STOP;
          else                   init_cnt <= init_cnt + 1'b1;
        S_STOP, S_DONE:
          if (arm_cmd) begin
            state    <= arm_state;
            pre_mode <= pre_nz;
            cnt      <= '0;
          end
        S_PRE:
          if (sample_stb) begin
            if (cnt_inc == pre_count) begin
              state <= S_WAIT;
              cnt   <= '0;
            end else cnt <= cnt_inc;
          end
        S_WAIT:
          if (start_trig) state <= S_SAMP;
        S_SAMP:
          if (stop_trig) begin
            cnt   <= '0;
            state <= post_nz ? S_POST : end_state;
          end
        S_POST:
          if (sample_stb) begin
            if (cnt_inc == post_count) begin
              state <= end_state;
              cnt   <= '0;
            end else cnt <= cnt_inc;
          end
        S_REARM:
          if (fifo_empty) begin
            state    <= arm_state;
            pre_mode <= pre_nz;
            cnt      <= '0;
          end
        default: state <= S_STOP;
      endcase
    end
  end

  assign status  = (state == S_UNINIT && !need_init) ? 4'h0 : state;
  assign fifo_wr = sample_stb && (state == S_PRE || state == S_SAMP || state == S_POST ||
                                  (state == S_WAIT && pre_mode));
endmodule

module adc_capture_seq_chk #(
  parameter int INIT_CYCLES = 16
) (
  input logic       clk,
  input logic       rst_n,
  input logic       reset_cmd,
  input logic       fifo_empty,
  input logic [3:0] status,
  input logic [3:0] state,
  input logic       sample_stb,
  input logic       fifo_wr
);
  int init_run;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)              init_run <= 0;
    else if (status == 4'h9) init_run <= init_run + 1;
    else                     init_run <= 0;

  assert_init_len_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (status == 4'h9) |-> (init_run < INIT_CYCLES));

  assert_write_on_strobe_R11: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_wr |-> sample_stb);

  assert_legal_status_R12: assert property (@(posedge clk) disable iff (!rst_n)
    status inside {4'h0, 4'h1, 4'h2, 4'h3, 4'h4, 4'h5, 4'h7, 4'h8, 4'h9});

  assert_rearm_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (state == 4'h5 && !fifo_empty && !reset_cmd) |=> (state == 4'h5));

  assert_idle_no_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (status inside {4'h0, 4'h5, 4'h7, 4'h8, 4'h9}) |-> !fifo_wr);

  assert_abort_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (reset_cmd && state != 4'h8 && state != 4'h9) |=> (status == 4'h0));
endmodule

bind adc_capture_seq adc_capture_seq_chk #(.INIT_CYCLES(INIT_CYCLES)) chk (
  .clk(clk), .rst_n(rst_n), .reset_cmd(reset_cmd), .fifo_empty(fifo_empty),
  .status(status), .state(state), .sample_stb(sample_stb), .fifo_wr(fifo_wr)
);

// File: tb/adc_capture_seq_test.sv
module adc_capture_seq_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic need_init = 1'b0, init_cmd = 1'b0, arm_cmd = 1'b0, reset_cmd = 1'b0;
  logic rearm_en = 1'b0, start_trig = 1'b0, stop_trig = 1'b0, fifo_empty = 1'b0;
  logic [7:0]  clk_div = 8'd4;
  logic [15:0] pre_count = '0, post_count = '0;
  logic [3:0]  status;
  logic        sample_stb, fifo_wr;

  int checks = 0;
  int failures = 0;
  int stray = 0;

  always #10 clk = ~clk;

  adc_capture_seq uut (
    .clk(clk), .rst_n(rst_n), .need_init(need_init), .init_cmd(init_cmd),
    .arm_cmd(arm_cmd), .reset_cmd(reset_cmd), .rearm_en(rearm_en),
    .start_trig(start_trig), .stop_trig(stop_trig), .fifo_empty(fifo_empty),
    .clk_div(clk_div), .pre_count(pre_count), .post_count(post_count),
    .status(status), .sample_stb(sample_stb), .fifo_wr(fifo_wr)
  );

  task automatic tick();
    @(negedge clk);
    if (fifo_wr && !sample_stb) stray++;
  endtask

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic pulse(ref logic sig);
    sig = 1'b1;
    tick();
    sig = 1'b0;
  endtask

  task automatic stay_in(input int code, input int max, output int writes, output int cycles);
    writes = 0;
    cycles = 0;
    while (status == 4'(code) && cycles < max) begin
      writes += int'(fifo_wr);
      cycles++;
      tick();
    end
  endtask

  task automatic writes_over(input int n, output int writes);
    writes = 0;
    for (int i = 0; i < n; i++) begin
      writes += int'(fifo_wr);
      tick();
    end
  endtask

  task automatic do_reset(input logic ni);
    need_init = ni;
    rst_n = 1'b0;
    tick();
    tick();
    chk("R1 status in reset", int'(status), ni ? 8 : 0);
    chk("R1 no write in reset", int'(fifo_wr), 0);
    rst_n = 1'b1;
    tick();
    chk("R1 status after reset", int'(status), ni ? 8 : 0);
  endtask

  task automatic t_init();
    int n;
    do_reset(1'b1);
    pulse(arm_cmd);
    chk("R2 arm ignored while uninitialized", int'(status), 8);
    pulse(init_cmd);
    n = 0;
    while (status == 4'h9 && n < 100) begin
      n++;
      tick();
    end
    chk("R2 init length", n, 16);
    chk("R2 stopped after init", int'(status), 0);
  endtask

  task automatic t_gap(input int div, input int exp, input string tag);
    int k, w;
    clk_div = 8'(div);
    tick();
    w = 0;
    while (!sample_stb && w < 600) begin
      w++;
      tick();
    end
    tick();
    k = 1;
    while (!sample_stb && k < 600) begin
      k++;
      tick();
    end
    chk(tag, k, exp);
  endtask

  task automatic t_divider();
    int n;
    t_gap(4, 8, "R3 period div=4");
    t_gap(5, 10, "R3 period div=5");
    t_gap(100, 200, "R3 period div=100");
    t_gap(2, 8, "R4 clamp div=2");
    t_gap(1, 8, "R4 clamp div=1");
    t_gap(150, 200, "R4 clamp div=150");
    clk_div = 8'd0;
    tick();
    n = 0;
    for (int i = 0; i < 300; i++) begin
      n += int'(sample_stb);
      tick();
    end
    chk("R3 no strobe div=0", n, 0);
    clk_div = 8'd4;
    tick();
  endtask

  task automatic t_prefill();
    int w, c;
    pre_count = 16'd3;
    post_count = 16'd5;
    rearm_en = 1'b0;
    pulse(arm_cmd);
    chk("R5 status after arm", int'(status), 1);
    stay_in(1, 500, w, c);
    chk("R5 pre-trigger writes", w, 3);
    chk("R5 waiting after fill", int'(status), 2);
    writes_over(24, w);
    chk("R5 circular writes while waiting", w, 3);
    chk("R7 holds without trigger", int'(status), 2);
    pulse(start_trig);
    chk("R7 sampling status", int'(status), 3);
    writes_over(24, w);
    chk("R7 writes while sampling", w, 3);
    pulse(stop_trig);
    chk("R8 post-stop status", int'(status), 4);
    stay_in(4, 500, w, c);
    chk("R8 post-stop writes", w, 5);
    chk("R8 done status", int'(status), 7);
    writes_over(24, w);
    chk("R8 no writes when done", w, 0);
  endtask

  task automatic t_nopre();
    int w;
    pre_count = 16'd0;
    post_count = 16'd0;
    pulse(arm_cmd);
    chk("R6 waits directly", int'(status), 2);
    writes_over(40, w);
    chk("R6 no writes before trigger", w, 0);
    pulse(start_trig);
    chk("R7 sampling status", int'(status), 3);
    writes_over(40, w);
    chk("R7 writes while sampling", w, 5);
    pulse(stop_trig);
    chk("R8 zero post count skips fill", int'(status), 7);
  endtask

  task automatic t_rearm();
    int w, c;
    pre_count = 16'd2;
    post_count = 16'd2;
    rearm_en = 1'b1;
    fifo_empty = 1'b0;
    pulse(arm_cmd);
    stay_in(1, 500, w, c);
    chk("R5 pre-trigger writes", w, 2);
    pulse(start_trig);
    pulse(stop_trig);
    stay_in(4, 500, w, c);
    chk("R8 post-stop writes", w, 2);
    chk("R9 rearm wait status", int'(status), 5);
    stay_in(5, 30, w, c);
    chk("R9 held while FIFO not empty", c, 30);
    chk("R9 no writes while waiting", w, 0);
    fifo_empty = 1'b1;
    tick();
    chk("R9 re-armed into pre-fill", int'(status), 1);
    fifo_empty = 1'b0;
    rearm_en = 1'b0;
  endtask

  task automatic t_abort();
    int w;
    pulse(reset_cmd);
    chk("R10 abort from pre-fill", int'(status), 0);
    writes_over(40, w);
    chk("R10 no writes after abort", w, 0);
    pre_count = 16'd0;
    pulse(arm_cmd);
    pulse(start_trig);
    chk("R7 sampling status", int'(status), 3);
    pulse(reset_cmd);
    chk("R10 abort from sampling", int'(status), 0);
    writes_over(40, w);
    chk("R10 no writes after abort", w, 0);
  endtask

  initial begin
    #3000000;
    failures++;
    $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    do_reset(1'b0);
    t_init();
    t_divider();
    do_reset(1'b0);
    t_prefill();
    t_nopre();
    t_rearm();
    t_abort();
    chk("R11 writes only on strobe", stray, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule